// File: doc/BRIEF.md
# Low Pin Count Memory Read Target

This block is the peripheral end of a Low Pin Count bus. It serves memory read cycles from a byte-wide storage array. It watches the active-low frame strobe and the 4-bit multiplexed address/data bus on every rising clock edge. When the host opens a cycle with a start nibble, the block checks the cycle-type nibble that follows. It then takes in a 32-bit address one nibble per clock. Next it takes over the bus in the turnaround, returns a sync nibble and then the addressed byte as two nibbles, and hands the bus back to the host.

The bus is modelled as a separate input nibble, an output nibble and an output enable, so a pad ring or a test bench can build the shared wire. The storage is a synchronous read-only byte array with `2**MEM_AW` entries. At power-up each entry at index `i` holds `i[7:0] ^ (i>>8)[7:0] ^ FILL_SEED`. If the host pulls the frame strobe low in the middle of a cycle, the cycle is abandoned: the block releases the bus and starts decoding again.

Top module: `lpc_rd_target`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, `lad_oe` is 0.
- R2: A cycle opens only when the edge samples `frame_n`=0, `lad_in`=0000b and `chip_en_n`=0. If the frame strobe stays low for several clocks, only the nibble sampled on the last clock before `frame_n` returns high decides whether a cycle opens.
- R3: The nibble sampled on the first clock with `frame_n` high is the cycle type. Bits 3:1 equal to 010b select a memory read, and bit 0 is ignored. Any other value returns the block to idle, and `lad_oe` stays 0.
- R4: The next eight nibbles form the 32-bit address, most significant nibble first. Only the low `MEM_AW` bits (default 10) select the byte. The byte returned is `i[7:0] ^ (i>>8)[7:0] ^ 8'h5A`, where `i` is that index.
- R5: `lad_oe` is 0 during the start, type, address and first turnaround clocks (fields 1 to 11). In field 12 it rises, with `lad_out`=1111b.
- R6: In field 13 the block drives the sync nibble 0000b.
- R7: Field 14 carries data bits 3:0 and field 15 carries data bits 7:4, with `lad_oe`=1 in both.
- R8: Field 16 drives 1111b. From field 17 on, `lad_oe` is 0.
- R9: A start nibble sampled while `chip_en_n` is 1 is ignored, so the following clocks produce no drive.
- R10: If an edge samples `frame_n`=0 in any field after the type nibble, the block drops `lad_oe` after that edge. If that sample is a start nibble with `chip_en_n`=0, the sample opens a new cycle, and the next nibble is its type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every field is sampled and driven on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en_n | input | 1 | Active-low select; must be low at the start nibble |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble the host places on the bus |
| lad_out | output | 4 | Nibble this block places on the bus |
| lad_oe | output | 1 | High while this block owns the bus |

## Verification
The hardest situation to reach is a new frame arriving at an exact field inside a running read, and above all one that arrives while the block itself owns the bus. The driver task takes a field number at which it swaps the planned nibble for a start code with the strobe low. It then starts the replacement cycle directly at its type nibble. Aborts are placed in the address phase, during sync and during the high data nibble. Each is followed by a full read, whose byte shows that decoding restarted cleanly. A long strobe with a stale non-start nibble in the middle, and one whose last nibble is not a start code, cover the rule that only the last nibble counts.

// File: rtl/lpc_rd_pkg.sv
// Package lpc_rd_pkg
// Shared state type and fixed nibble codes for the read target.
// Assumes: the state encoding is internal; only the checker looks at it.
package lpc_rd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTYPE,
        ST_ADDR,
        ST_TAR0,
        ST_TAR1,
        ST_SYNC,
        ST_DLO,
        ST_DHI,
        ST_TEND
    } lrd_state_e;

    localparam logic [3:0] NIB_START = 4'h0;
    localparam logic [3:0] NIB_SYNC  = 4'h0;
    localparam logic [3:0] NIB_HIGH  = 4'hF;
    localparam logic [2:0] CTYPE_MRD = 3'b010;

endpackage

// File: rtl/lpc_rd_seq.sv
// Module lpc_rd_seq
// Field sequencer: follows the frame strobe and the inbound nibble,
// decides which field the next clock belongs to, and raises the
// address-shift and storage-read strobes.
// Assumes: all inputs are synchronous to clk; a low frame strobe
// overrides every other field (start, or abort of a running cycle).
module lpc_rd_seq
    import lpc_rd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_en_n,
    input  logic       frame_n,
    input  logic [3:0] lad_in,
    output lrd_state_e state,
    output logic       shift_en,
    output logic       rd_en
);

    localparam int NIB_CNT = ADDR_W / 4;
    localparam int CNT_W   = (NIB_CNT > 1) ? $clog2(NIB_CNT) : 1;

    lrd_state_e       state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    // Next-field decision; a low strobe wins over the running sequence.
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        if (!frame_n) begin
            if (lad_in == NIB_START && !chip_en_n) state_nxt = ST_CTYPE;
            else                                   state_nxt = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  state_nxt = ST_IDLE;
                ST_CTYPE: begin
                    if (lad_in[3:1] == CTYPE_MRD) begin
                        state_nxt = ST_ADDR;
                        cnt_nxt   = '0;
                    end else begin
                        state_nxt = ST_IDLE;
                    end
                end
                ST_ADDR: begin
                    if (cnt == CNT_W'(NIB_CNT - 1)) state_nxt = ST_TAR0;
                    else                            cnt_nxt   = cnt + CNT_W'(1);
                end
                ST_TAR0:  state_nxt = ST_TAR1;
                ST_TAR1:  state_nxt = ST_SYNC;
                ST_SYNC:  state_nxt = ST_DLO;
                ST_DLO:   state_nxt = ST_DHI;
                ST_DHI:   state_nxt = ST_TEND;
                ST_TEND:  state_nxt = ST_IDLE;
                default:  state_nxt = ST_IDLE;
            endcase
        end
    end

    // State and nibble-counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Strobes for the address register and the storage port.
    always_comb begin
        shift_en = frame_n && (state == ST_ADDR);
        rd_en    = frame_n && (state == ST_TAR0);
    end

endmodule

// File: rtl/lpc_rd_addr.sv
// Module lpc_rd_addr
// Address collector: shifts inbound nibbles in, most significant first,
// and keeps only the low KEEP_W bits that the storage decodes.
// Assumes: shift_en is high exactly once per address nibble.
module lpc_rd_addr #(
    parameter int KEEP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [3:0]        lad_in,
    output logic [KEEP_W-1:0] addr
);

    // Shift the new nibble in at the low end; upper bits fall off.
    always_ff @(posedge clk) begin
        if (!rst_n)        addr <= '0;
        else if (shift_en) addr <= KEEP_W'({addr, lad_in});
    end

endmodule

// File: rtl/lpc_rd_store.sv
// Module lpc_rd_store
// Byte storage behind a one-cycle synchronous read port. The contents
// are filled at power-up with a pattern computed from the index.
// Assumes: no write path; rd_addr is stable on the rd_en edge.
module lpc_rd_store #(
    parameter int          MEM_AW    = 10,
    parameter logic [7:0]  FILL_SEED = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0] mem [DEPTH];

    // Power-up fill: low index byte mixed with the next byte and the seed.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = 8'(i) ^ 8'(i >> 8) ^ FILL_SEED;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/lpc_rd_drive.sv
// Module lpc_rd_drive
// Outbound nibble and enable decode from the current field.
// Assumes: state is a register, so both outputs change only after edges.
module lpc_rd_drive
    import lpc_rd_pkg::*;
(
    input  lrd_state_e state,
    input  logic [7:0] rd_data,
    output logic [3:0] lad_out,
    output logic       lad_oe
);

    // Pick the nibble for the field this block owns; float otherwise.
    always_comb begin
        lad_oe  = 1'b1;
        lad_out = NIB_HIGH;
        case (state)
            ST_TAR1: lad_out = NIB_HIGH;
            ST_SYNC: lad_out = NIB_SYNC;
            ST_DLO:  lad_out = rd_data[3:0];
            ST_DHI:  lad_out = rd_data[7:4];
            ST_TEND: lad_out = NIB_HIGH;
            default: lad_oe  = 1'b0;
        endcase
    end

endmodule

// File: rtl/lpc_rd_target.sv
// Module lpc_rd_target
// Low Pin Count memory read target: decodes start, type and address
// fields, turns the bus around, returns sync and one byte, releases.
// Assumes: the host forms the shared bus from lad_in, lad_out, lad_oe.
module lpc_rd_target
    import lpc_rd_pkg::*;
#(
    parameter int         ADDR_W    = 32,
    parameter int         MEM_AW    = 10,
    parameter logic [7:0] FILL_SEED = 8'h5A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_en_n,
    input  logic       frame_n,
    input  logic [3:0] lad_in,
    output logic [3:0] lad_out,
    output logic       lad_oe
);

    lrd_state_e        seq_state;
    logic              shift_en;
    logic              rd_en;
    logic [MEM_AW-1:0] byte_addr;
    logic [7:0]        rd_data;

    lpc_rd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_en_n (chip_en_n),
        .frame_n   (frame_n),
        .lad_in    (lad_in),
        .state     (seq_state),
        .shift_en  (shift_en),
        .rd_en     (rd_en)
    );

    lpc_rd_addr #(.KEEP_W(MEM_AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .lad_in   (lad_in),
        .addr     (byte_addr)
    );

    lpc_rd_store #(.MEM_AW(MEM_AW), .FILL_SEED(FILL_SEED)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (byte_addr),
        .rd_data (rd_data)
    );

    lpc_rd_drive u_drive (
        .state   (seq_state),
        .rd_data (rd_data),
        .lad_out (lad_out),
        .lad_oe  (lad_oe)
    );

endmodule

// File: rtl/lpc_rd_target_chk.sv
// Module lpc_rd_target_chk
// Protocol checker for the read target, attached with bind.
// Assumes: seq_state is the sequencer's registered field state.
module lpc_rd_target_chk
    import lpc_rd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       chip_en_n,
    input logic       frame_n,
    input logic [3:0] lad_in,
    input logic [3:0] lad_out,
    input logic       lad_oe,
    input lrd_state_e seq_state
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !lad_oe);                                            // R1

    AST_START_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_IDLE && chip_en_n) |=> seq_state == ST_IDLE);  // R9

    AST_TYPE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_CTYPE && frame_n && lad_in[3:1] != 3'b010)
        |=> (seq_state == ST_IDLE && !lad_oe));                         // R3

    AST_HOST_FIELDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state inside {ST_IDLE, ST_CTYPE, ST_ADDR, ST_TAR0}) |-> !lad_oe); // R5

    AST_TAR_TAKEOVER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lad_oe) |-> lad_out == 4'hF);                             // R5

    AST_SYNC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lad_oe) && frame_n) |=> (lad_oe && lad_out == 4'h0));    // R6

    AST_END_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_TEND && lad_oe && frame_n)
        |-> (lad_out == 4'hF) ##1 !lad_oe);                             // R8

    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && lad_oe) |=> !lad_oe);                              // R10

endmodule

bind lpc_rd_target lpc_rd_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en_n (chip_en_n),
    .frame_n   (frame_n),
    .lad_in    (lad_in),
    .lad_out   (lad_out),
    .lad_oe    (lad_oe),
    .seq_state (seq_state)
);

// File: tb/test_lpc_rd_target.sv
// Scoreboard bench: the driver pushes, for every clock it drives, the
// expected bus state after the next edge; the monitor pops and compares.
module test_lpc_rd_target;

    localparam int         MEM_AW = 10;
    localparam logic [7:0] SEED   = 8'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_en_n = 1'b0;
    logic       frame_n = 1'b1;
    logic [3:0] lad_in = 4'hF;
    logic [3:0] lad_out;
    logic       lad_oe;

    always #5 clk = ~clk;

    lpc_rd_target #(.ADDR_W(32), .MEM_AW(MEM_AW), .FILL_SEED(SEED)) i_lpc_rd_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_en_n (chip_en_n),
        .frame_n   (frame_n),
        .lad_in    (lad_in),
        .lad_out   (lad_out),
        .lad_oe    (lad_oe)
    );

    typedef struct {
        bit         oe;
        logic [3:0] nib;
        string      req;
    } exp_t;

    exp_t sb[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Expected byte per R4: index i is the low MEM_AW address bits.
    function automatic logic [7:0] ref_byte(logic [31:0] a);
        int i = int'(a[MEM_AW-1:0]);
        return 8'(i) ^ 8'(i >> 8) ^ SEED;
    endfunction

    // Drive one field and push what the bus must show after its edge.
    task automatic step(bit fr, logic [3:0] nib, bit ce, bit eoe, logic [3:0] enib, string req);
        exp_t e;
        @(negedge clk);
        frame_n   = fr;
        lad_in    = nib;
        chip_en_n = ce;
        e.oe  = eoe;
        e.nib = enib;
        e.req = req;
        sb.push_back(e);
    endtask

    // One read; ok says whether it must be answered. abort_at replaces
    // that field with a new start nibble and ends the task there.
    task automatic run_read(logic [31:0] a, logic [3:0] ct, bit ce, bit ok,
                            int abort_at, bit with_start, string rej);
        logic [7:0] d = ref_byte(a);
        bit         eo  [17:11];
        logic [3:0] en  [17:11];
        string      rq  [17:11];
        eo[11] = 1; en[11] = 4'hF;   rq[11] = "R5";
        eo[12] = 1; en[12] = 4'h0;   rq[12] = "R6";
        eo[13] = 1; en[13] = d[3:0]; rq[13] = "R4/R7";
        eo[14] = 1; en[14] = d[7:4]; rq[14] = "R4/R7";
        eo[15] = 1; en[15] = 4'hF;   rq[15] = "R8";
        eo[16] = 0; en[16] = 4'hF;   rq[16] = "R8";
        eo[17] = 0; en[17] = 4'hF;   rq[17] = "R8";
        if (with_start) step(1'b0, 4'h0, ce, 1'b0, 4'hF, ok ? "R2" : rej);
        step(1'b1, ct, ce, 1'b0, 4'hF, ok ? "R3" : rej);
        for (int k = 3; k <= 10; k++) begin
            if (k == abort_at) begin
                step(1'b0, 4'h0, 1'b0, 1'b0, 4'hF, "R10");
                return;
            end
            step(1'b1, a[(31 - 4*(k-3)) -: 4], ce, 1'b0, 4'hF, ok ? "R5" : rej);
        end
        for (int k = 11; k <= 17; k++) begin
            if (k == abort_at) begin
                step(1'b0, 4'h0, 1'b0, 1'b0, 4'hF, "R10");
                return;
            end
            step(1'b1, 4'hF, ce, ok && eo[k], en[k], ok ? rq[k] : rej);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b1, 4'hF, 1'b0, 1'b0, 4'hF, "R8");
    endtask

    // Monitor: compare the bus a little after each rising edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                n_cmp++;
                if (lad_oe !== e.oe || (e.oe && lad_out !== e.nib)) begin
                    n_bad++;
                    $display("FAIL %s: actual oe=%0b out=%h, expected oe=%0b out=%h",
                             e.req, lad_oe, lad_out, e.oe, e.nib);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (lad_oe !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: actual oe=%0b, expected oe=0 in reset", lad_oe);
        end
        rst_n = 1'b1;
        idle(2);

        // Plain reads, bit 0 of type ignored, high address bits ignored.
        run_read(32'h0000_0123, 4'h4, 1'b0, 1'b1, 0, 1'b1, "");
        idle(1);
        run_read(32'hFFFF_FC05, 4'h5, 1'b0, 1'b1, 0, 1'b1, "");
        run_read(32'h0000_02C7, 4'h4, 1'b0, 1'b1, 0, 1'b1, "");

        // R2: long strobe, stale non-start nibble, then the last start counts.
        step(1'b0, 4'h5, 1'b0, 1'b0, 4'hF, "R2");
        step(1'b0, 4'h0, 1'b0, 1'b0, 4'hF, "R2");
        run_read(32'h1234_56A9, 4'h4, 1'b0, 1'b1, 0, 1'b1, "");

        // R2: last nibble before the strobe rises is not a start code.
        step(1'b0, 4'h0, 1'b0, 1'b0, 4'hF, "R2");
        step(1'b0, 4'h3, 1'b0, 1'b0, 4'hF, "R2");
        run_read(32'h0000_0011, 4'h4, 1'b0, 1'b0, 0, 1'b0, "R2");

        // R3: write, other cycle types.
        run_read(32'h0000_0040, 4'h6, 1'b0, 1'b0, 0, 1'b1, "R3");
        run_read(32'h0000_0041, 4'hC, 1'b0, 1'b0, 0, 1'b1, "R3");
        run_read(32'h0000_0042, 4'h0, 1'b0, 1'b0, 0, 1'b1, "R3");

        // R9: chip enable high at the start nibble.
        run_read(32'h0000_0077, 4'h4, 1'b1, 1'b0, 0, 1'b1, "R9");
        run_read(32'h0000_0078, 4'h4, 1'b0, 1'b1, 0, 1'b1, "");

        // R10: aborts in the address phase, during sync, during high data.
        run_read(32'h0000_0100, 4'h4, 1'b0, 1'b1, 5, 1'b1, "");
        run_read(32'hABCD_E2F0, 4'h4, 1'b0, 1'b1, 0, 1'b0, "");
        run_read(32'h0000_0200, 4'h4, 1'b0, 1'b1, 13, 1'b1, "");
        run_read(32'h0000_03FF, 4'h4, 1'b0, 1'b1, 0, 1'b0, "");
        run_read(32'h0000_0300, 4'h4, 1'b0, 1'b1, 15, 1'b1, "");
        run_read(32'h0000_0155, 4'h5, 1'b0, 1'b1, 0, 1'b0, "");
        idle(3);

        while (sb.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule